// File: doc/BRIEF.md
# PLL frequency crawl sequencer

This block retunes a clock PLL that is already running, moving it to a new VCO frequency without switching it off. On a start pulse it captures the present and the wanted configuration: for each, the VCO frequency, the reference frequency and the output clock frequency, all as unsigned integers in the same unit. It then decides whether the move can be made as a crawl, in which the PLL stays enabled and only its multiplier changes.

When a crawl is allowed, the block issues three writes toward the PLL control register. It first loads the new multiplier with the enable bit set. It then raises the frequency request. When the PLL reports that it is locked and that it has taken the request, or when a timeout runs out, it drops the request. When a crawl is not allowed, it writes nothing and raises a flag asking for the slow path, in which the PLL is disabled and then enabled again. That slow path is left to other logic.

The multiplier and the two output dividers are found with small sequential dividers that round to nearest. A busy output covers the whole operation, and a done pulse marks its end.

Top module: `pll_crawl_seq`

## Requirements
- R1: A crawl is made only when all of the following hold: both VCO values are nonzero, they differ, the two reference frequencies are equal, and the rounded divider VCO/output is the same for the present and the wanted configuration. When a crawl is not made and R7 does not apply, `needsFull` goes high, no register write occurs, and `done` pulses.
- R2: Bits 7:0 of every crawl write hold round(wanted VCO / wanted reference), where a tie rounds up (for example 100/8 gives 13). A result above 255 saturates to 255.
- R3: Bit 31 (PLL enable) is 1 in every write.
- R4: A crawl makes exactly three writes. The first has bit 23 (request) at 0. The second follows in the very next cycle, with the same word and bit 23 at 1. The third carries bit 23 at 0 and the same ratio. All other bits of each word are 0.
- R5: After the request write, the third write waits until `pllLock` and `pllAck` are both 1 in the same cycle. Lock alone is not enough.
- R6: If lock and acknowledge are not seen together within TIMEOUT_US × CLK_MHZ cycles of waiting, `error` goes high and the third write is still made. `error` stays high until the next accepted start, which clears it.
- R7: When both VCO values are equal and nonzero, no write occurs, `needsFull` and `error` stay low, and `done` pulses.
- R8: `liveVco` takes the wanted VCO value at the end of every crawl, whether it ended by acknowledge or by timeout. Otherwise it keeps its value.
- R9: `busy` is high from the cycle after an accepted start through the cycle in which `done` is high, and is low after it. `done` is a single-cycle pulse. A start while busy is ignored.
- R10: After reset, `busy`, `done`, `error`, `needsFull` and `regWrEn` are 0 and `liveVco` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| curVco | input | VCO_W | Present VCO frequency |
| curRef | input | VCO_W | Present reference frequency |
| curOut | input | VCO_W | Present output clock frequency |
| tgtVco | input | VCO_W | Wanted VCO frequency |
| tgtRef | input | VCO_W | Wanted reference frequency |
| tgtOut | input | VCO_W | Wanted output clock frequency |
| pllLock | input | 1 | PLL lock status |
| pllAck | input | 1 | PLL frequency-request acknowledge |
| regWrEn | output | 1 | Control register write strobe |
| regWrData | output | 32 | Control register write word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| error | output | 1 | Acknowledge timeout seen (sticky until next start) |
| needsFull | output | 1 | Crawl not allowed; full disable/re-enable needed |
| liveVco | output | VCO_W | VCO value the PLL was last crawled to |

## Verification
The assertions assume that the PLL side answers only through `pllLock` and `pllAck`, and that those inputs never affect the write path outside the wait. They also assume that `start` can be pulsed at any time, including while an operation runs. The bench PLL model raises lock and acknowledge only a set number of cycles after it sees a request write, and it drops the acknowledge on the clearing write. The output and reference frequencies given to the block are always nonzero. One extra start is pulsed in the middle of a crawl, to cover the ignored-start case.

// File: rtl/pll_crawl_pkg.sv
package pll_crawl_pkg;

  localparam int ENABLE_BIT = 31;
  localparam int REQ_BIT    = 23;
  localparam int RATIO_W    = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIVIDE,
    ST_DECIDE,
    ST_WR_RATIO,
    ST_WR_REQ,
    ST_WAIT,
    ST_WR_CLR,
    ST_FINISH
  } ctrlState_t;

  typedef struct packed {
    logic load;
    logic wrRatio;
    logic wrReq;
    logic wrClr;
    logic tick;
    logic setErr;
    logic setFull;
  } strobe_t;

  typedef struct packed {
    logic divReady;
    logic eligible;
    logic sameVco;
    logic ackSeen;
    logic tmrZero;
  } dpStat_t;

endpackage

// File: rtl/pll_crawl_div.sv
module pll_crawl_div #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W:0]   quot,
  output logic         ready
);
  localparam int NW = W + 1;
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] numR;
  logic [NW:0]   remR;
  logic [NW-1:0] quotR;
  logic [W-1:0]  dvsR;
  logic [CW-1:0] cntR;
  logic          running;
  logic          readyR;
  logic [NW:0]   trial;
  logic [NW:0]   dvsExt;

  assign trial  = {remR[NW-1:0], numR[NW-1]};
  assign dvsExt = {2'b00, dvsR};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      numR    <= '0;
      remR    <= '0;
      quotR   <= '0;
      dvsR    <= '0;
      cntR    <= '0;
      running <= 1'b0;
      readyR  <= 1'b0;
    end else if (start) begin
      // Adding half the divisor before truncating rounds to nearest.
      numR    <= NW'(dividend) + NW'(divisor >> 1);
      remR    <= '0;
      quotR   <= '0;
      dvsR    <= divisor;
      cntR    <= CW'(NW);
      running <= 1'b1;
      readyR  <= 1'b0;
    end else if (running) begin
      if (trial >= dvsExt) begin
        remR  <= trial - dvsExt;
        quotR <= {quotR[NW-2:0], 1'b1};
      end else begin
        remR  <= trial;
        quotR <= {quotR[NW-2:0], 1'b0};
      end
      numR <= numR << 1;
      cntR <= cntR - CW'(1);
      if (cntR == CW'(1)) begin
        running <= 1'b0;
        readyR  <= 1'b1;
      end
    end
  end

  assign quot  = quotR;
  assign ready = readyR;
endmodule

// File: rtl/pll_crawl_dp.sv
module pll_crawl_dp
  import pll_crawl_pkg::*;
#(
  parameter int VCO_W       = 16,
  parameter int TIMEOUT_CYC = 20000
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [VCO_W-1:0] curVco,
  input  logic [VCO_W-1:0] curRef,
  input  logic [VCO_W-1:0] curOut,
  input  logic [VCO_W-1:0] tgtVco,
  input  logic [VCO_W-1:0] tgtRef,
  input  logic [VCO_W-1:0] tgtOut,
  input  logic             pllLock,
  input  logic             pllAck,
  output dpStat_t          stat,
  output logic             regWrEn,
  output logic [31:0]      regWrData,
  output logic             error,
  output logic             needsFull,
  output logic [VCO_W-1:0] liveVco
);
  localparam int N_DIV = 3;
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam int DIV_CUR = 0;
  localparam int DIV_TGT = 1;
  localparam int DIV_RAT = 2;

  logic [VCO_W-1:0] cV, tV, cR, tR;
  logic [VCO_W-1:0] divA [N_DIV];
  logic [VCO_W-1:0] divB [N_DIV];
  logic [VCO_W:0]   divQ [N_DIV];
  logic [N_DIV-1:0] divRdy;
  logic [TMR_W-1:0] tmrR;
  logic [RATIO_W-1:0] ratio;

  assign divA[DIV_CUR] = curVco;
  assign divB[DIV_CUR] = curOut;
  assign divA[DIV_TGT] = tgtVco;
  assign divB[DIV_TGT] = tgtOut;
  assign divA[DIV_RAT] = tgtVco;
  assign divB[DIV_RAT] = tgtRef;

  for (genvar i = 0; i < N_DIV; i++) begin : g_div
    pll_crawl_div #(.W(VCO_W)) div_i (
      .clk     (clk),
      .rstN    (rstN),
      .start   (stb.load),
      .dividend(divA[i]),
      .divisor (divB[i]),
      .quot    (divQ[i]),
      .ready   (divRdy[i])
    );
  end

  assign ratio = (|divQ[DIV_RAT][VCO_W:RATIO_W]) ? '1 : divQ[DIV_RAT][RATIO_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cV <= '0;
      tV <= '0;
      cR <= '0;
      tR <= '0;
    end else if (stb.load) begin
      cV <= curVco;
      tV <= tgtVco;
      cR <= curRef;
      tR <= tgtRef;
    end
  end

  assign stat.divReady = &divRdy;
  assign stat.sameVco  = (cV != '0) && (cV == tV);
  assign stat.eligible = (cV != '0) && (tV != '0) && (cV != tV) && (cR == tR) &&
                         (divQ[DIV_CUR] == divQ[DIV_TGT]);
  assign stat.ackSeen  = pllLock & pllAck;
  assign stat.tmrZero  = (tmrR == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrR <= '0;
    end else if (stb.wrReq) begin
      tmrR <= TMR_W'(TIMEOUT_CYC - 1);
    end else if (stb.tick) begin
      tmrR <= tmrR - TMR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regWrEn   <= 1'b0;
      regWrData <= '0;
    end else begin
      regWrEn <= stb.wrRatio | stb.wrReq | stb.wrClr;
      if (stb.wrRatio | stb.wrReq | stb.wrClr) begin
        regWrData                <= '0;
        regWrData[ENABLE_BIT]    <= 1'b1;
        regWrData[REQ_BIT]       <= stb.wrReq;
        regWrData[RATIO_W-1:0]   <= ratio;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      error     <= 1'b0;
      needsFull <= 1'b0;
      liveVco   <= '0;
    end else begin
      if (stb.load) begin
        error     <= 1'b0;
        needsFull <= 1'b0;
      end else begin
        if (stb.setErr)  error     <= 1'b1;
        if (stb.setFull) needsFull <= 1'b1;
      end
      if (stb.wrClr) liveVco <= tV;
    end
  end
endmodule

// File: rtl/pll_crawl_ctrl.sv
module pll_crawl_ctrl
  import pll_crawl_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  dpStat_t stat,
  output strobe_t stb,
  output logic    busy,
  output logic    done
);
  ctrlState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    stb      = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          stb.load = 1'b1;
          stateNxt = ST_DIVIDE;
        end
      end
      ST_DIVIDE: begin
        if (stat.divReady) stateNxt = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (stat.sameVco) begin
          stateNxt = ST_FINISH;
        end else if (stat.eligible) begin
          stateNxt = ST_WR_RATIO;
        end else begin
          stb.setFull = 1'b1;
          stateNxt    = ST_FINISH;
        end
      end
      ST_WR_RATIO: begin
        stb.wrRatio = 1'b1;
        stateNxt    = ST_WR_REQ;
      end
      ST_WR_REQ: begin
        stb.wrReq = 1'b1;
        stateNxt  = ST_WAIT;
      end
      ST_WAIT: begin
        if (stat.ackSeen) begin
          stateNxt = ST_WR_CLR;
        end else if (stat.tmrZero) begin
          stb.setErr = 1'b1;
          stateNxt   = ST_WR_CLR;
        end else begin
          stb.tick = 1'b1;
        end
      end
      ST_WR_CLR: begin
        stb.wrClr = 1'b1;
        stateNxt  = ST_FINISH;
      end
      ST_FINISH: stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH);
endmodule

// File: rtl/pll_crawl_seq.sv
module pll_crawl_seq
  import pll_crawl_pkg::*;
#(
  parameter int VCO_W      = 16,
  parameter int CLK_MHZ    = 100,
  parameter int TIMEOUT_US = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [VCO_W-1:0] curVco,
  input  logic [VCO_W-1:0] curRef,
  input  logic [VCO_W-1:0] curOut,
  input  logic [VCO_W-1:0] tgtVco,
  input  logic [VCO_W-1:0] tgtRef,
  input  logic [VCO_W-1:0] tgtOut,
  input  logic             pllLock,
  input  logic             pllAck,
  output logic             regWrEn,
  output logic [31:0]      regWrData,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             needsFull,
  output logic [VCO_W-1:0] liveVco
);
  localparam int TIMEOUT_CYC = CLK_MHZ * TIMEOUT_US;

  strobe_t stb;
  dpStat_t stat;

  pll_crawl_ctrl ctrl_i (
    .clk (clk),
    .rstN(rstN),
    .start(start),
    .stat(stat),
    .stb (stb),
    .busy(busy),
    .done(done)
  );

  pll_crawl_dp #(.VCO_W(VCO_W), .TIMEOUT_CYC(TIMEOUT_CYC)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .curVco   (curVco),
    .curRef   (curRef),
    .curOut   (curOut),
    .tgtVco   (tgtVco),
    .tgtRef   (tgtRef),
    .tgtOut   (tgtOut),
    .pllLock  (pllLock),
    .pllAck   (pllAck),
    .stat     (stat),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .error    (error),
    .needsFull(needsFull),
    .liveVco  (liveVco)
  );
endmodule

// File: rtl/pll_crawl_chk.sv
module pll_crawl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        regWrEn,
  input logic [31:0] regWrData,
  input logic        busy,
  input logic        done,
  input logic        error,
  input logic        needsFull
);
  // R3: enable bit present in every write
  a_r3_enable_kept: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> regWrData[31]);

  // R1: a full-reconfig request never comes with a write
  a_r1_full_no_write: assert property (@(posedge clk) disable iff (!rstN)
    needsFull |-> !regWrEn);

  // R4: the write after the ratio write is the request, same ratio
  a_r4_pair: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && $past(regWrEn) && $past(rstN)) |->
      (regWrData[23] && !$past(regWrData[23]) && regWrData[7:0] == $past(regWrData[7:0])));

  // R4: after the request there is a gap for the wait
  a_r4_req_wait: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrData[23]) |=> !regWrEn);

  // R9: writes only inside an operation
  a_r9_write_busy: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> busy);

  // R9: done ends busy and lasts one cycle
  a_r9_done_ends: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!busy && !done));

  // R6: error holds until a start
  a_r6_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (error && !start) |=> error);
endmodule

bind pll_crawl_seq pll_crawl_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .busy     (busy),
  .done     (done),
  .error    (error),
  .needsFull(needsFull)
);

// File: tb/pll_crawl_seq_tb.sv
module pll_crawl_seq_tb_top;
  localparam int W = 16;
  localparam int TMO = 100 * 200;

  typedef struct packed {
    int cv; int cr; int co;
    int tv; int tr; int to;
    int ackDly;
    int kind;   // 0 crawl, 1 unchanged, 2 full reconfig
    int ratio;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1920, 38, 480, 2304, 38,  576, 3, 0, 61},
    '{2304, 38, 576, 1920, 38,  480, 1, 0, 51},
    '{1920, 38, 480, 2304, 19,  576, 1, 2, 0},
    '{1920, 38, 480, 2304, 38, 1152, 1, 2, 0},
    '{0,    38, 480, 2304, 38,  576, 1, 2, 0},
    '{1920, 38, 480, 0,    38,  480, 1, 2, 0},
    '{1920, 38, 480, 1920, 38,  480, 1, 1, 0},
    '{60,    8,  15, 100,   8,   25, 0, 0, 13},
    '{1000, 10, 300, 1100, 10,  350, 5, 0, 110},
    '{206,  10, 103, 103,  10,   51, 2, 0, 10}
  };

  logic clk = 0, rstN = 0, start = 0;
  logic [W-1:0] curVco = 0, curRef = 0, curOut = 0, tgtVco = 0, tgtRef = 0, tgtOut = 0;
  logic pllLock, pllAck;
  logic regWrEn, busy, done, error, needsFull;
  logic [31:0] regWrData;
  logic [W-1:0] liveVco;

  int nTests = 0, nFail = 0;
  int ackDelay = 1;
  bit lockOnly = 0;
  int nWr = 0;
  logic [31:0] wrLog [64];
  int expLive = 0;

  always #5 clk = ~clk;

  pll_crawl_seq dut_i (
    .clk(clk), .rstN(rstN), .start(start),
    .curVco(curVco), .curRef(curRef), .curOut(curOut),
    .tgtVco(tgtVco), .tgtRef(tgtRef), .tgtOut(tgtOut),
    .pllLock(pllLock), .pllAck(pllAck),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .busy(busy), .done(done), .error(error),
    .needsFull(needsFull), .liveVco(liveVco)
  );

  // PLL model: answers a request write after ackDelay cycles
  int dly;
  bit pend;
  always @(posedge clk) begin
    if (!rstN) begin
      pllLock <= 0; pllAck <= 0; pend <= 0; dly <= 0;
    end else if (regWrEn && regWrData[23]) begin
      pend <= 1; dly <= ackDelay;
    end else if (regWrEn) begin
      pllAck <= 0; pend <= 0;
    end else if (pend) begin
      if (dly == 0) begin
        pllLock <= 1; pllAck <= !lockOnly; pend <= 0;
      end else if (dly > 0) begin
        dly <= dly - 1;
      end
    end
  end

  always @(posedge clk) begin
    if (regWrEn) begin
      if (nWr < 64) wrLog[nWr] <= regWrData;
      nWr <= nWr + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulseStart(input int cv, cr, co, tv, tr, to);
    @(negedge clk);
    curVco = W'(cv); curRef = W'(cr); curOut = W'(co);
    tgtVco = W'(tv); tgtRef = W'(tr); tgtOut = W'(to);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic waitDone(output int cyc);
    cyc = 1;
    while (!done && cyc < 30000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL R9 done never seen actual=0 expected=1");
    end
    @(negedge clk);
  endtask

  task automatic checkCrawl(input string tag, input int base, input int ratio, input bit expErr, input int tv);
    logic [31:0] w0;
    w0 = 32'h8000_0000 | 32'(ratio);
    chk({tag, " R4 write count"}, 32'(nWr - base), 32'd3);
    chk({tag, " R2 R3 ratio write"}, wrLog[base], w0);
    chk({tag, " R4 request write"}, wrLog[base+1], w0 | 32'h0080_0000);
    chk({tag, " R4 clear write"}, wrLog[base+2], w0);
    chk({tag, " R6 error"}, 32'(error), 32'(expErr));
    chk({tag, " R1 needsFull"}, 32'(needsFull), 32'd0);
    expLive = tv;
    chk({tag, " R8 liveVco"}, 32'(liveVco), 32'(expLive));
    chk({tag, " R9 busy after done"}, 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int cyc, base;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 busy", 32'(busy), 0);
    chk("R10 done", 32'(done), 0);
    chk("R10 error", 32'(error), 0);
    chk("R10 needsFull", 32'(needsFull), 0);
    chk("R10 regWrEn", 32'(regWrEn), 0);
    chk("R10 liveVco", 32'(liveVco), 0);

    for (int i = 0; i < NV; i++) begin
      ackDelay = VECS[i].ackDly;
      base = nWr;
      pulseStart(VECS[i].cv, VECS[i].cr, VECS[i].co, VECS[i].tv, VECS[i].tr, VECS[i].to);
      chk($sformatf("vec%0d R9 busy after start", i), 32'(busy), 1);
      waitDone(cyc);
      if (VECS[i].kind == 0) begin
        checkCrawl($sformatf("vec%0d", i), base, VECS[i].ratio, 0, VECS[i].tv);
      end else begin
        chk($sformatf("vec%0d R1 R7 no writes", i), 32'(nWr - base), 0);
        chk($sformatf("vec%0d R1 R7 needsFull", i), 32'(needsFull), 32'(VECS[i].kind == 2));
        chk($sformatf("vec%0d R7 error", i), 32'(error), 0);
        chk($sformatf("vec%0d R8 liveVco kept", i), 32'(liveVco), 32'(expLive));
      end
    end

    // R5: lock alone never completes the wait; R6 timeout
    lockOnly = 1; ackDelay = 2;
    base = nWr;
    pulseStart(1000, 10, 250, 1200, 10, 300);
    waitDone(cyc);
    chk("R5 R6 timeout window", 32'(cyc >= TMO && cyc <= TMO + 60), 1);
    checkCrawl("lockonly", base, 120, 1, 1200);
    repeat (5) @(negedge clk);
    chk("R6 error held", 32'(error), 1);

    // R6 no answer at all; then the next start clears the error
    lockOnly = 0; ackDelay = -1;
    base = nWr;
    pulseStart(1200, 10, 300, 1400, 10, 350);
    waitDone(cyc);
    checkCrawl("noack", base, 140, 1, 1400);
    ackDelay = 1;
    base = nWr;
    pulseStart(1400, 10, 350, 1200, 10, 300);
    waitDone(cyc);
    checkCrawl("R6 clear", base, 120, 0, 1200);

    // R9 start while busy is ignored
    ackDelay = 20;
    base = nWr;
    pulseStart(1200, 10, 300, 1000, 10, 250);
    repeat (20) @(negedge clk);
    start = 1; tgtRef = 5;
    @(negedge clk);
    start = 0;
    waitDone(cyc);
    checkCrawl("R9 ignored start", base, 100, 0, 1000);
    repeat (30) @(negedge clk);
    chk("R9 no second run busy", 32'(busy), 0);
    chk("R9 no second run writes", 32'(nWr - base), 3);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule